// File: doc/BRIEF.md
# EPP 1.9 Host Handshake Engine

This block sits between a host I/O bus and the peripheral side of an enhanced parallel port. The host selects the address register or the data register and pulls its read or write strobe low. The engine turns that access into one handshaked port cycle. It uses the address strobe or the data strobe, the WRITE line and the peripheral's WAIT line. While the port cycle is in progress, the host ready line stays low, which stretches the host access. Read data is captured from the port data lines at the moment WAIT rises.

The port data bus is presented as separate input, output and output-enable signals. The pad drivers that would merge them lie outside the block. The WRITE line also marks the bus direction. It stays low after a write, so the block keeps driving the last byte. It returns high when a read starts. It also returns high when the host has requested the reverse direction, no cycle is pending and the peripheral has pulled WAIT low. A programmable timeout ends a handshake that never completes and raises a timeout flag. WAIT is assumed to be synchronous to the block clock.

Top module: `epp_host_engine`

## Requirements
- R1: In reset and on the first cycle after it, astrb_n, dstrb_n and write_n are 1, host_rdy is 1, pd_oe is 0, tmo_flag is 0 and host_rdata is 0.
- R2: While host_rd_n or host_wr_n is low, host_rdy is 0 in the same cycle, without waiting for a clock edge. It stays 0 until the port cycle has completed or timed out. With both strobes high, host_rdy is 1.
- R3: If wait_n is high when a cycle starts, both port strobes stay high. The selected strobe goes low on the first clock edge at which wait_n is sampled low.
- R4: If wait_n is already low when the access is first seen, the selected strobe goes low on that first clock edge. There is no separate waiting step.
- R5: While a strobe is low, the first clock edge that samples wait_n high ends the cycle. On a read, that edge loads pd_in into host_rdata. The strobe returns high on the same edge, and host_rdy is 1 from then on while the host strobe is still held.
- R6: A value of 0 on host_sel uses astrb_n and a value of 1 uses dstrb_n. The two strobes are never low at the same time.
- R7: On a write, the first clock edge of the cycle sets write_n to 0, puts host_wdata on pd_out and raises pd_oe. The strobe handshake then follows R3 to R5.
- R8: On a read, the first clock edge of the cycle sets write_n to 1 and pd_oe to 0. After host_rd_n returns high, pd_oe stays 0.
- R9: After a write, while ctl_dir is 0, write_n stays 0 and pd_oe stays 1 through idle time, whatever wait_n does.
- R10: When no cycle is in progress, ctl_dir is 1 and wait_n is sampled low, the next clock edge sets write_n to 1 and pd_oe to 0. With wait_n high, or while a write cycle is in progress, write_n stays 0.
- R11: If the handshake is not complete after tmo_limit+1 clock edges in the handshake states, the cycle ends. Both strobes go high, host_rdy rises and tmo_flag is set. tmo_flag clears on the first edge of the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_rd_n | input | 1 | Host read strobe, active low, held for the whole access |
| host_wr_n | input | 1 | Host write strobe, active low, held for the whole access |
| host_sel | input | 1 | Register select: 0 address register, 1 data register |
| host_wdata | input | DW | Byte written by the host |
| host_rdata | output | DW | Byte captured by the last completed read |
| host_rdy | output | 1 | Host ready; low stretches the host access |
| ctl_dir | input | 1 | Direction request from the control register, 1 = reverse |
| tmo_limit | input | TMO_W | Handshake timeout limit in clock edges |
| tmo_flag | output | 1 | Set when a cycle was ended by the timeout |
| wait_n | input | 1 | Peripheral WAIT handshake line |
| astrb_n | output | 1 | Address strobe, active low |
| dstrb_n | output | 1 | Data strobe, active low |
| write_n | output | 1 | Port WRITE line, low for writes and forward direction |
| pd_in | input | DW | Port data lines as received |
| pd_out | output | DW | Port data to drive |
| pd_oe | output | 1 | Output enable for pd_out |

## Verification
The hardest states to reach are the direction turnaround and the pending-write case. The turnaround needs an idle port that still holds WRITE low from a previous write, then the reverse request, then WAIT pulled low, and each of those three is checked apart. The bench first finishes a write so that WRITE is left low. It then raises the reverse request with WAIT high and checks that nothing changes before it lowers WAIT. After that it starts a write with the reverse request already set and WAIT already low, which shows that a pending write keeps WRITE low. A timeout is reached by holding WAIT high through a read with a small limit. The next cycle then has to show the flag cleared.

// File: rtl/epp_pkg.sv
// Shared types for the EPP host handshake engine.
// Assumes: one port cycle at a time; state names are used by all submodules.
package epp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no cycle in progress
        ST_WLO  = 2'd1,   // waiting for WAIT low, strobe high
        ST_STB  = 2'd2,   // strobe low, waiting for WAIT high
        ST_DONE = 2'd3    // cycle over, waiting for the host to release
    } epp_state_t;
endpackage

// File: rtl/epp_tmo.sv
// Handshake timeout counter.
// Counts clock edges while a handshake is running and flags expiry when the
// count equals the programmed limit. Assumes the limit is stable during a cycle.
module epp_tmo #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt;

    assign expired = run && (cnt == limit);

    // Count handshake edges, hold at the limit, clear between cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/epp_fsm.sv
// Port cycle sequencer: host access detection, strobe handshake with WAIT,
// read data capture, host ready and timeout abort.
// Assumes wait_n is synchronous to clk and the host holds its strobe until
// host_rdy is seen high.
module epp_fsm
    import epp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_rd_n,
    input  logic          host_wr_n,
    input  logic          host_sel,
    input  logic          wait_n,
    input  logic [DW-1:0] pd_in,
    input  logic          expired,
    output logic          astrb_n,
    output logic          dstrb_n,
    output logic [DW-1:0] host_rdata,
    output logic          host_rdy,
    output logic          tmo_flag,
    output logic          hs_run,
    output logic          start_rd,
    output logic          start_wr,
    output logic          quiet
);
    epp_state_t    state;
    logic          req;
    logic          start;
    logic          sel_q;
    logic          is_rd_q;
    logic          stb_q;

    assign req      = !host_rd_n || !host_wr_n;
    assign start    = (state == ST_IDLE) && req;
    assign start_rd = start && !host_rd_n;
    assign start_wr = start && host_rd_n && !host_wr_n;
    assign quiet    = (state == ST_IDLE) && !req;
    assign hs_run   = (state == ST_WLO) || (state == ST_STB);
    assign host_rdy = !(req && (state != ST_DONE));

    // Route the single active strobe to the register that was selected.
    assign astrb_n = stb_q || sel_q;
    assign dstrb_n = stb_q || !sel_q;

    // Sequence one port cycle per host access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sel_q      <= 1'b0;
            is_rd_q    <= 1'b0;
            stb_q      <= 1'b1;
            tmo_flag   <= 1'b0;
            host_rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        tmo_flag <= 1'b0;
                        sel_q    <= host_sel;
                        is_rd_q  <= !host_rd_n;
                        if (!wait_n) begin
                            state <= ST_STB;
                            stb_q <= 1'b0;
                        end else begin
                            state <= ST_WLO;
                        end
                    end
                end
                ST_WLO: begin
                    if (!wait_n) begin
                        state <= ST_STB;
                        stb_q <= 1'b0;
                    end else if (expired) begin
                        state    <= ST_DONE;
                        tmo_flag <= 1'b1;
                    end
                end
                ST_STB: begin
                    if (wait_n) begin
                        stb_q <= 1'b1;
                        state <= ST_DONE;
                        if (is_rd_q) begin
                            host_rdata <= pd_in;
                        end
                    end else if (expired) begin
                        stb_q    <= 1'b1;
                        state    <= ST_DONE;
                        tmo_flag <= 1'b1;
                    end
                end
                default: begin
                    if (!req) begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/epp_dir.sv
// Port direction and output data control.
// WRITE low means forward direction and enables the output driver. A write
// start drives it low, a read start or an idle turnaround drives it high.
// Assumes the turnaround request is a level from the control register.
module epp_dir #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_rd,
    input  logic          start_wr,
    input  logic          quiet,
    input  logic          ctl_dir,
    input  logic          wait_n,
    input  logic [DW-1:0] host_wdata,
    output logic          write_n,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe
);
    logic turn;

    assign turn  = quiet && ctl_dir && !wait_n;
    assign pd_oe = !write_n;

    // Track the bus direction through cycle starts and idle turnaround.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_n <= 1'b1;
        end else if (start_wr) begin
            write_n <= 1'b0;
        end else if (start_rd || turn) begin
            write_n <= 1'b1;
        end
    end

    // Capture the host byte at the start of a write cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_out <= '0;
        end else if (start_wr) begin
            pd_out <= host_wdata;
        end
    end
endmodule

// File: rtl/epp_host_engine.sv
// EPP host handshake engine top: joins the cycle sequencer, the timeout
// counter and the direction control. Assumes the pad logic merges pd_out,
// pd_oe and pd_in into the bidirectional port bus.
module epp_host_engine #(
    parameter int DW    = 8,
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_rd_n,
    input  logic             host_wr_n,
    input  logic             host_sel,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic             host_rdy,
    input  logic             ctl_dir,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             tmo_flag,
    input  logic             wait_n,
    output logic             astrb_n,
    output logic             dstrb_n,
    output logic             write_n,
    input  logic [DW-1:0]    pd_in,
    output logic [DW-1:0]    pd_out,
    output logic             pd_oe
);
    logic hs_run;
    logic expired;
    logic start_rd;
    logic start_wr;
    logic quiet;

    epp_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rd_n  (host_rd_n),
        .host_wr_n  (host_wr_n),
        .host_sel   (host_sel),
        .wait_n     (wait_n),
        .pd_in      (pd_in),
        .expired    (expired),
        .astrb_n    (astrb_n),
        .dstrb_n    (dstrb_n),
        .host_rdata (host_rdata),
        .host_rdy   (host_rdy),
        .tmo_flag   (tmo_flag),
        .hs_run     (hs_run),
        .start_rd   (start_rd),
        .start_wr   (start_wr),
        .quiet      (quiet)
    );

    epp_tmo #(.TMO_W(TMO_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hs_run),
        .limit   (tmo_limit),
        .expired (expired)
    );

    epp_dir #(.DW(DW)) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_rd   (start_rd),
        .start_wr   (start_wr),
        .quiet      (quiet),
        .ctl_dir    (ctl_dir),
        .wait_n     (wait_n),
        .host_wdata (host_wdata),
        .write_n    (write_n),
        .pd_out     (pd_out),
        .pd_oe      (pd_oe)
    );
endmodule

// File: rtl/epp_host_engine_chk.sv
// Protocol checker for the EPP host handshake engine, bound to the top.
// Assumes a well-behaved host that holds its strobe until host_rdy is high.
module epp_host_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic host_rd_n,
    input logic ctl_dir,
    input logic wait_n,
    input logic astrb_n,
    input logic dstrb_n,
    input logic write_n,
    input logic host_rdy,
    input logic tmo_flag
);
    logic both_hi;

    assign both_hi = astrb_n && dstrb_n;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!astrb_n && !dstrb_n)); // R6

    AST_RDY_LOW_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !both_hi |-> !host_rdy); // R2

    AST_FALL_AFTER_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(both_hi) |-> !$past(wait_n)); // R3

    AST_RISE_AFTER_WAIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(both_hi) |-> ($past(wait_n) || tmo_flag)); // R5

    AST_WRITE_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(write_n) |-> ($past(!host_rd_n) || $past(ctl_dir && !wait_n))); // R10

    AST_TMO_RELEASES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> both_hi); // R11
endmodule

bind epp_host_engine epp_host_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_rd_n (host_rd_n),
    .ctl_dir   (ctl_dir),
    .wait_n    (wait_n),
    .astrb_n   (astrb_n),
    .dstrb_n   (dstrb_n),
    .write_n   (write_n),
    .host_rdy  (host_rdy),
    .tmo_flag  (tmo_flag)
);

// File: tb/epp_host_engine_tb.sv
// Self-checking bench: a vector table of host cycles, then directed tests
// for reset, direction turnaround, pending write and timeout.
module epp_host_engine_tb;
    localparam int DW    = 8;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_rd_n = 1'b1;
    logic             host_wr_n = 1'b1;
    logic             host_sel = 1'b0;
    logic [DW-1:0]    host_wdata = '0;
    logic [DW-1:0]    host_rdata;
    logic             host_rdy;
    logic             ctl_dir = 1'b0;
    logic [TMO_W-1:0] tmo_limit = 8'd20;
    logic             tmo_flag;
    logic             wait_n = 1'b1;
    logic             astrb_n;
    logic             dstrb_n;
    logic             write_n;
    logic [DW-1:0]    pd_in = '0;
    logic [DW-1:0]    pd_out;
    logic             pd_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // {is_wr, sel, wait_low_at_start, spare, wdata, pd_in}
    localparam logic [19:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA5},
        {1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h3C},
        {1'b1, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h00},
        {1'b1, 1'b1, 1'b1, 1'b0, 8'hC3, 8'h00},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h96},
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h0F, 8'h00}
    };

    always #5 clk = ~clk;

    epp_host_engine #(.DW(DW), .TMO_W(TMO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdy(host_rdy), .ctl_dir(ctl_dir), .tmo_limit(tmo_limit),
        .tmo_flag(tmo_flag), .wait_n(wait_n), .astrb_n(astrb_n),
        .dstrb_n(dstrb_n), .write_n(write_n), .pd_in(pd_in), .pd_out(pd_out),
        .pd_oe(pd_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One host cycle with the peripheral handshake driven by the bench.
    task automatic run_vec(input logic [19:0] v);
        logic          is_wr = v[19];
        logic          sel   = v[18];
        logic          pre   = v[17];
        logic [DW-1:0] wd    = v[15:8];
        logic [DW-1:0] pdv   = v[7:0];
        logic          s_sel;
        logic          s_oth;
        wait_n     = !pre;
        host_sel   = sel;
        host_wdata = wd;
        if (is_wr) host_wr_n = 1'b0; else host_rd_n = 1'b0;
        #1;
        check(host_rdy == 1'b0, "R2 ready low at access", host_rdy, 0);
        edges(1);
        s_sel = sel ? dstrb_n : astrb_n;
        s_oth = sel ? astrb_n : dstrb_n;
        if (pre) begin
            check(s_sel == 1'b0, "R4 strobe low on first edge", s_sel, 0);
        end else begin
            check(astrb_n && dstrb_n, "R3 strobes high before WAIT low",
                  {astrb_n, dstrb_n}, 2'b11);
            wait_n = 1'b0;
            edges(1);
            s_sel = sel ? dstrb_n : astrb_n;
            s_oth = sel ? astrb_n : dstrb_n;
            check(s_sel == 1'b0, "R3 strobe low after WAIT low", s_sel, 0);
        end
        check(s_oth == 1'b1, "R6 other strobe high", s_oth, 1);
        check(host_rdy == 1'b0, "R2 ready low during strobe", host_rdy, 0);
        if (is_wr)
            check(!write_n && pd_oe && pd_out == wd, "R7 write drives bus",
                  {write_n, pd_oe, pd_out}, {1'b0, 1'b1, wd});
        else
            check(write_n && !pd_oe, "R8 read releases bus",
                  {write_n, pd_oe}, 2'b10);
        pd_in  = pdv;
        wait_n = 1'b1;
        edges(1);
        check(astrb_n && dstrb_n && host_rdy, "R5 strobe high and ready",
              {astrb_n, dstrb_n, host_rdy}, 3'b111);
        if (!is_wr)
            check(host_rdata == pdv, "R5 read data latched", host_rdata, pdv);
        pd_in     = 8'hEE;
        host_rd_n = 1'b1;
        host_wr_n = 1'b1;
        wait_n    = 1'b0;
        edges(2);
        if (is_wr)
            check(!write_n && pd_oe, "R9 write direction held in idle",
                  {write_n, pd_oe}, 2'b01);
        else
            check(!pd_oe && host_rdy, "R8 bus released after read",
                  {pd_oe, host_rdy}, 2'b01);
        wait_n = 1'b1;
        edges(1);
    endtask

    initial begin
        #(20000 * 10);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        edges(2);
        check(astrb_n && dstrb_n && write_n && host_rdy && !pd_oe && !tmo_flag
              && host_rdata == 0, "R1 state in reset",
              {astrb_n, dstrb_n, write_n, host_rdy, pd_oe, tmo_flag}, 6'b111100);
        rst_n = 1'b1;
        edges(1);
        check(astrb_n && dstrb_n && write_n && !pd_oe && !tmo_flag,
              "R1 state after reset", {astrb_n, dstrb_n, write_n, pd_oe, tmo_flag},
              5'b11100);

        foreach (VEC[i]) run_vec(VEC[i]);

        // R10 turnaround: WRITE is low after the last write.
        ctl_dir = 1'b1;
        wait_n  = 1'b1;
        edges(2);
        check(write_n == 1'b0, "R10 no turnaround while WAIT high", write_n, 0);
        wait_n = 1'b0;
        edges(1);
        check(write_n && !pd_oe, "R10 turnaround on WAIT low",
              {write_n, pd_oe}, 2'b10);
        wait_n = 1'b1;
        edges(1);

        // R10 pending write keeps WRITE low despite reverse request.
        wait_n     = 1'b0;
        host_sel   = 1'b1;
        host_wdata = 8'h77;
        host_wr_n  = 1'b0;
        edges(2);
        check(!write_n && pd_oe && pd_out == 8'h77, "R10 pending write holds WRITE",
              {write_n, pd_oe, pd_out}, {2'b01, 8'h77});
        wait_n = 1'b1;
        edges(1);
        host_wr_n = 1'b1;
        edges(1);
        check(write_n == 1'b0, "R10 idle with WAIT high keeps WRITE", write_n, 0);
        wait_n = 1'b0;
        edges(1);
        check(write_n == 1'b1, "R10 turnaround after pending write", write_n, 1);
        wait_n  = 1'b1;
        ctl_dir = 1'b0;
        edges(1);

        // R11 timeout with WAIT stuck high.
        tmo_limit = 8'd5;
        host_sel  = 1'b0;
        host_rd_n = 1'b0;
        edges(3);
        check(!host_rdy && !tmo_flag, "R11 no early timeout",
              {host_rdy, tmo_flag}, 2'b00);
        edges(5);
        check(host_rdy && tmo_flag && astrb_n && dstrb_n, "R11 timeout aborts",
              {host_rdy, tmo_flag, astrb_n, dstrb_n}, 4'b1111);
        host_rd_n = 1'b1;
        edges(2);
        wait_n    = 1'b0;
        host_rd_n = 1'b0;
        edges(1);
        check(tmo_flag == 1'b0, "R11 flag clears on next cycle", tmo_flag, 0);
        pd_in  = 8'h42;
        wait_n = 1'b1;
        edges(1);
        check(host_rdata == 8'h42 && host_rdy, "R5 read after timeout",
              host_rdata, 8'h42);
        host_rd_n = 1'b1;
        edges(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule